// File: doc/BRIEF.md
# Wavefront Issue Scheduler

This block decides, cycle by cycle, which resident wavefront of a compute unit issues its next instruction. The unit has several SIMD engines, each holding a fixed number of wave slots. An allocate port places a wave into a slot and a retire port frees it. A per-slot wait vector marks the waves that are stalled on memory.

A turn pointer rotates over the SIMDs, one step per clock. Because a wave instruction keeps its SIMD occupied for one full rotation (a quarter of the wave per cycle), each SIMD gets exactly one issue opportunity per rotation. On its turn, a SIMD scans its slots in round-robin order from its own pointer. The scan passes over empty, waiting and still-executing waves. The chosen SIMD and slot appear on the issue outputs in the same cycle, with a valid strobe.

The block has no notion of where a wave came from. Graphics-stage waves and compute-queue waves compete on equal terms and may share a SIMD.

Top module: `wave_issue_sched`

## Requirements
- R1: After reset, every slot is empty and `issue_valid` is low. The turn in the first cycle after reset is SIMD 0.
- R2: The turn moves to the next SIMD every cycle, wrapping from NUM_SIMD-1 to 0. An issue only ever comes from the SIMD whose turn it is.
- R3: An issued wave is resident and its wait bit is low. The wait bit of SIMD s, slot j is `wave_wait[s*SLOTS_PER_SIMD + j]`.
- R4: On its turn, a SIMD issues the first eligible slot found by scanning upward from its round-robin pointer, wrapping past the last slot. After an issue, the pointer becomes one past the issued slot.
- R5: A wave issued in cycle t is not eligible again before cycle t+EXEC_CYCLES.
- R6: When no slot of the turn SIMD is eligible, `issue_valid` is low, `issue_simd` and `issue_slot` read 0, and that SIMD's pointer does not move.
- R7: A wave whose wait bit is high is skipped. It becomes eligible again in the same cycle its wait bit drops.
- R8: A retired slot is empty from the next cycle on. When an allocate and a retire target the same slot in the same cycle, the retire wins.
- R9: An allocated slot is resident and not busy from the next cycle on, even if its previous occupant was still inside its execution window.
- R10: An allocate or retire whose slot index is SLOTS_PER_SIMD or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Place a wave into a slot |
| alloc_simd | input | SIMD_W | SIMD of the slot to fill |
| alloc_slot | input | SLOT_W | Slot index to fill |
| retire_en | input | 1 | Free a slot |
| retire_simd | input | SIMD_W | SIMD of the slot to free |
| retire_slot | input | SLOT_W | Slot index to free |
| wave_wait | input | NUM_SIMD*SLOTS_PER_SIMD | Memory-wait flag per slot, index simd*SLOTS_PER_SIMD+slot |
| issue_valid | output | 1 | A wave issues this cycle |
| issue_simd | output | SIMD_W | SIMD of the issuing wave |
| issue_slot | output | SLOT_W | Slot of the issuing wave |

## Verification
The bench builds the block with four SIMDs, ten slots per SIMD and EXEC_CYCLES set to 6. Because the execution window is longer than one four-cycle rotation, per-wave busy tracking changes what is observed: a lone wave issues every eight cycles instead of every four. Ten slots is not a power of two, so the pointer wrap from slot 9 to slot 0 is exercised. The 4-bit slot field can also carry the unused indices 10 to 15, which the bench sends to test R10.

// File: rtl/wis_pkg.sv
package wis_pkg;

   // Successor of an index in a ring of n entries.
   function automatic int unsigned wis_ring_next(input int unsigned cur, input int unsigned n);
      return (cur + 1 >= n) ? 0 : cur + 1;
   endfunction

endpackage

// File: rtl/wis_turn_ctr.sv
module wis_turn_ctr #(
   parameter int NUM_SIMD = 4,
   parameter int SIMD_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [SIMD_W-1:0] turn_o
);

   logic [SIMD_W-1:0] turn_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         turn_q <= '0;
      else if (turn_q == SIMD_W'(NUM_SIMD - 1))
         turn_q <= '0;
      else
         turn_q <= turn_q + 1'b1;
   end

   assign turn_o = turn_q;

   // R2: the turn never leaves the legal SIMD range
   a_r2_turn_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(turn_q) < NUM_SIMD);

endmodule

// File: rtl/wis_slot_table.sv
module wis_slot_table #(
   parameter int SLOTS       = 10,
   parameter int EXEC_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SLOTS-1:0] alloc_hit,
   input  logic [SLOTS-1:0] retire_hit,
   input  logic [SLOTS-1:0] issue_hit,
   output logic [SLOTS-1:0] valid_o,
   output logic [SLOTS-1:0] busy_o
);

   localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

   generate
      for (genvar j = 0; j < SLOTS; j++) begin : g_slot
         logic             valid_q;
         logic [CNT_W-1:0] left_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q <= 1'b0;
               left_q  <= '0;
            end else if (retire_hit[j]) begin
               valid_q <= 1'b0;
               left_q  <= '0;
            end else if (alloc_hit[j]) begin
               valid_q <= 1'b1;
               left_q  <= '0;
            end else if (issue_hit[j]) begin
               left_q  <= CNT_W'(EXEC_CYCLES - 1);
            end else if (left_q != '0) begin
               left_q  <= left_q - 1'b1;
            end
         end

         assign valid_o[j] = valid_q;
         assign busy_o[j]  = (left_q != '0);

         // R5: only an idle resident wave may be issued
         a_r5_issue_idle: assert property (@(posedge clk) disable iff (!rst_n)
            issue_hit[j] |-> (valid_o[j] && !busy_o[j]));

         // R8: a retire empties the slot for the next cycle
         a_r8_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
            retire_hit[j] |=> !valid_o[j]);

         // R9: an allocate (not overridden by a retire) yields an idle resident slot
         a_r9_alloc_fills: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_hit[j] && !retire_hit[j]) |=> (valid_o[j] && !busy_o[j]));
      end
   endgenerate

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
   parameter int SLOTS  = 10,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOTS-1:0]  elig_i,
   input  logic              take_i,
   output logic              found_o,
   output logic [SLOT_W-1:0] slot_o
);

   logic [SLOT_W-1:0] rr_q;

   always_comb begin
      logic [SLOT_W:0] idx;
      found_o = 1'b0;
      slot_o  = '0;
      for (int k = 0; k < SLOTS; k++) begin
         idx = {1'b0, rr_q} + (SLOT_W + 1)'(k);
         if (idx >= (SLOT_W + 1)'(SLOTS))
            idx = idx - (SLOT_W + 1)'(SLOTS);
         if (!found_o && elig_i[idx[SLOT_W-1:0]]) begin
            found_o = 1'b1;
            slot_o  = idx[SLOT_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rr_q <= '0;
      else if (take_i && found_o)
         rr_q <= (slot_o == SLOT_W'(SLOTS - 1)) ? '0 : slot_o + 1'b1;
   end

   // R6: pointer holds when this SIMD does not issue
   a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(take_i && found_o) |=> $stable(rr_q));

   // R4: the reported slot is one of the eligible ones
   a_r4_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> elig_i[slot_o]);

endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
   import wis_pkg::*;
#(
   parameter  int NUM_SIMD       = 4,
   parameter  int SLOTS_PER_SIMD = 10,
   parameter  int EXEC_CYCLES    = 4,
   localparam int SIMD_W         = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
   localparam int SLOT_W         = $clog2(SLOTS_PER_SIMD),
   localparam int WAVES          = NUM_SIMD * SLOTS_PER_SIMD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [SIMD_W-1:0] alloc_simd,
   input  logic [SLOT_W-1:0] alloc_slot,
   input  logic              retire_en,
   input  logic [SIMD_W-1:0] retire_simd,
   input  logic [SLOT_W-1:0] retire_slot,
   input  logic [WAVES-1:0]  wave_wait,
   output logic              issue_valid,
   output logic [SIMD_W-1:0] issue_simd,
   output logic [SLOT_W-1:0] issue_slot
);

   localparam int WIDX_W = $clog2(WAVES);

   generate
      if (NUM_SIMD < 2) begin : g_bad_simd
         $error("wave_issue_sched: NUM_SIMD must be at least 2");
      end
      if (SLOTS_PER_SIMD < 2) begin : g_bad_slots
         $error("wave_issue_sched: SLOTS_PER_SIMD must be at least 2");
      end
      if (EXEC_CYCLES < 1) begin : g_bad_exec
         $error("wave_issue_sched: EXEC_CYCLES must be at least 1");
      end
   endgenerate

   logic [SIMD_W-1:0] turn;

   wis_turn_ctr #(
      .NUM_SIMD (NUM_SIMD),
      .SIMD_W   (SIMD_W)
   ) u_turn (
      .clk    (clk),
      .rst_n  (rst_n),
      .turn_o (turn)
   );

   logic [NUM_SIMD-1:0] found_v;
   logic [SLOT_W-1:0]   slot_v [NUM_SIMD];

   generate
      for (genvar s = 0; s < NUM_SIMD; s++) begin : g_simd
         logic [SLOTS_PER_SIMD-1:0] a_hit, r_hit, i_hit, valid, busy, elig;
         logic                      take;

         assign take = (turn == SIMD_W'(s));

         for (genvar j = 0; j < SLOTS_PER_SIMD; j++) begin : g_dec
            assign a_hit[j] = alloc_en  && (alloc_simd  == SIMD_W'(s)) && (alloc_slot  == SLOT_W'(j));
            assign r_hit[j] = retire_en && (retire_simd == SIMD_W'(s)) && (retire_slot == SLOT_W'(j));
            assign i_hit[j] = take && found_v[s] && (slot_v[s] == SLOT_W'(j));
         end

         assign elig = valid & ~busy & ~wave_wait[s*SLOTS_PER_SIMD +: SLOTS_PER_SIMD];

         wis_slot_table #(
            .SLOTS       (SLOTS_PER_SIMD),
            .EXEC_CYCLES (EXEC_CYCLES)
         ) u_table (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_hit  (a_hit),
            .retire_hit (r_hit),
            .issue_hit  (i_hit),
            .valid_o    (valid),
            .busy_o     (busy)
         );

         wis_rr_pick #(
            .SLOTS  (SLOTS_PER_SIMD),
            .SLOT_W (SLOT_W)
         ) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .elig_i  (elig),
            .take_i  (take),
            .found_o (found_v[s]),
            .slot_o  (slot_v[s])
         );
      end
   endgenerate

   always_comb begin
      issue_valid = 1'b0;
      issue_simd  = '0;
      issue_slot  = '0;
      for (int s = 0; s < NUM_SIMD; s++) begin
         if (turn == SIMD_W'(s) && found_v[s]) begin
            issue_valid = 1'b1;
            issue_simd  = SIMD_W'(s);
            issue_slot  = slot_v[s];
         end
      end
   end

   // ---------------- assertions ----------------
   logic [SIMD_W-1:0] simd_succ;
   logic [WIDX_W-1:0] wait_idx;

   assign simd_succ = SIMD_W'(wis_ring_next(int'(issue_simd), NUM_SIMD));
   assign wait_idx  = WIDX_W'(issue_simd) * WIDX_W'(SLOTS_PER_SIMD) + WIDX_W'(issue_slot);

   // R2: back-to-back issues come from consecutive SIMDs
   a_r2_turn_order: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && $past(issue_valid)) |-> (issue_simd == $past(simd_succ)));

   // R3: an issued wave is never one that waits on memory
   a_r3_not_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !wave_wait[wait_idx]);

   // R6: idle outputs read zero
   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |-> (issue_simd == '0 && issue_slot == '0));

endmodule

// File: tb/tb_wave_issue_sched.sv
module tb_wave_issue_sched;

   localparam int CLK_PERIOD = 10;
   localparam int NS   = 4;
   localparam int SL   = 10;
   localparam int EX   = 6;
   localparam int SW   = 2;
   localparam int LW   = 4;
   localparam int NW   = NS * SL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_en = 1'b0;
   logic [SW-1:0] alloc_simd = '0;
   logic [LW-1:0] alloc_slot = '0;
   logic          retire_en = 1'b0;
   logic [SW-1:0] retire_simd = '0;
   logic [LW-1:0] retire_slot = '0;
   logic [NW-1:0] wave_wait = '0;
   logic          issue_valid;
   logic [SW-1:0] issue_simd;
   logic [LW-1:0] issue_slot;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wave_issue_sched #(
      .NUM_SIMD       (NS),
      .SLOTS_PER_SIMD (SL),
      .EXEC_CYCLES    (EX)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_en    (alloc_en),
      .alloc_simd  (alloc_simd),
      .alloc_slot  (alloc_slot),
      .retire_en   (retire_en),
      .retire_simd (retire_simd),
      .retire_slot (retire_slot),
      .wave_wait   (wave_wait),
      .issue_valid (issue_valid),
      .issue_simd  (issue_simd),
      .issue_slot  (issue_slot)
   );

   // behavioural reference state
   bit m_valid [NS][SL];
   int m_left  [NS][SL];
   int m_rr    [NS];
   int m_turn;
   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic model_reset();
      for (int s = 0; s < NS; s++) begin
         m_rr[s] = 0;
         for (int j = 0; j < SL; j++) begin
            m_valid[s][j] = 1'b0;
            m_left[s][j]  = 0;
         end
      end
      m_turn = 0;
   endtask

   // One clock: drive at the falling edge, compare, then advance the model.
   task automatic cyc(input string tag,
                      input bit ae, input int as, input int aj,
                      input bit re, input int rs, input int rj);
      bit e_v;
      int e_j;
      alloc_en    = ae;  alloc_simd  = SW'(as); alloc_slot  = LW'(aj);
      retire_en   = re;  retire_simd = SW'(rs); retire_slot = LW'(rj);
      #1;
      e_v = 1'b0;
      e_j = 0;
      for (int k = 0; k < SL; k++) begin
         int j;
         j = (m_rr[m_turn] + k) % SL;
         if (!e_v && m_valid[m_turn][j] && m_left[m_turn][j] == 0 && !wave_wait[m_turn*SL + j]) begin
            e_v = 1'b1;
            e_j = j;
         end
      end
      n_cmp++;
      if (issue_valid !== e_v ||
          (e_v  && (int'(issue_simd) != m_turn || int'(issue_slot) != e_j)) ||
          (!e_v && (issue_simd !== '0 || issue_slot !== '0))) begin
         n_fail++;
         $display("FAIL %s: got v=%0b simd=%0d slot=%0d, expected v=%0b simd=%0d slot=%0d",
                  tag, issue_valid, issue_simd, issue_slot, e_v, e_v ? m_turn : 0, e_j);
      end
      @(posedge clk);
      for (int s = 0; s < NS; s++)
         for (int j = 0; j < SL; j++)
            if (m_left[s][j] > 0) m_left[s][j]--;
      if (e_v) begin
         m_left[m_turn][e_j] = EX - 1;
         m_rr[m_turn] = (e_j + 1) % SL;
      end
      if (ae && aj < SL) begin m_valid[as][aj] = 1'b1; m_left[as][aj] = 0; end
      if (re && rj < SL) begin m_valid[rs][rj] = 1'b0; m_left[rs][rj] = 0; end
      m_turn = (m_turn + 1) % NS;
      @(negedge clk);
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) cyc(tag, 1'b0, 0, 0, 1'b0, 0, 0);
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset, nothing issues
      idle("R1", 6);

      // R5: a lone wave on SIMD 0 issues only every 8 cycles with EX=6
      cyc("R5", 1'b1, 0, 3, 1'b0, 0, 0);
      idle("R5", 24);

      // R9: fill every slot; R2 rotation and R4 order follow
      for (int s = 0; s < NS; s++)
         for (int j = 0; j < SL; j++)
            cyc("R9", 1'b1, s, j, 1'b0, 0, 0);
      idle("R2", 16);

      // R7: waiting waves are skipped
      wave_wait = {NW/2{2'b01}};
      idle("R7", 20);
      wave_wait = '1;
      wave_wait[1*SL + 7] = 1'b0;
      idle("R7", 20);

      // R6: every wave waits, no issue, pointers hold
      wave_wait = '1;
      idle("R6", 12);
      wave_wait = '0;
      idle("R6", 8);

      // R8: retire all of SIMD 1, then alloc+retire on the same slot
      for (int j = 0; j < SL; j++) cyc("R8", 1'b0, 0, 0, 1'b1, 1, j);
      idle("R8", 8);
      cyc("R8", 1'b1, 2, 4, 1'b1, 2, 4);
      idle("R8", 8);

      // R10: out-of-range slot indices leave SIMD 1 empty and SIMD 2 intact
      cyc("R10", 1'b1, 1, 12, 1'b0, 0, 0);
      cyc("R10", 1'b1, 1, 15, 1'b1, 2, 11);
      idle("R10", 8);

      // R4 / R3: mixed random traffic
      for (int i = 0; i < 600; i++) begin
         wave_wait = NW'({$urandom(), $urandom()} & {$urandom(), $urandom()});
         cyc("R4", ($urandom_range(0, 9) < 4), $urandom_range(0, NS-1), $urandom_range(0, 15),
                   ($urandom_range(0, 9) < 3), $urandom_range(0, NS-1), $urandom_range(0, 15));
      end
      wave_wait = '0;
      idle("R3", 12);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: got no end of run, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

endmodule